// File: doc/BRIEF.md
# Flash Memory Device Bus Front-End

This block is the device-side control logic of a small NAND-style flash memory. It accepts the usual asynchronous bus strobes: chip enable, command latch, address latch, write strobe and read strobe. It samples them with a synchronous system clock and turns their edges into command writes, address writes, data-in writes and serial data-out reads. A page buffer sits between the bus and a small register-file array that stands in for the memory cells. Read, program and erase operations move data between the buffer and the array while a ready flag is held low. Each operation type has its own busy length, set by a parameter.

The data bus is `IO_W` bits wide, so the block covers both the 8-bit and the 16-bit organisation. Command and address cycles only ever look at bits 7..0. Program and erase requests are refused while write protect is low, or while a global lock is set. The lock is armed through a strap input. While an operation is busy, the block ignores chip enable going high and keeps running. Every strobe edge takes effect three clock cycles after the pin changes: two synchroniser stages, then one register stage. Parameters must satisfy `T_RD >= 2**COL_W + 1`, `T_PG >= 2**COL_W`, `T_ER >= 2**(COL_W+BLK_AW)` and `1 <= BLK_AW < PAGE_AW`.

Top module: `flash_bus_fe`

## Requirements
- R1: With `chip_en_n` low, a rising `wr_stb_n` while `cmd_latch` is high and `addr_latch` is low captures `dq_in[7:0]` as a command; bits above 7 are ignored. Codes: 8'h00 read setup, 8'h30 read go, 8'h80 program setup, 8'h10 program go, 8'h60 erase setup, 8'hD0 erase go. Any other code, or a go code without its matching setup, returns the block to idle.
- R2: After a setup command, the first two address cycles (`addr_latch` high, `cmd_latch` low, rising `wr_stb_n`) load the column from `dq_in[COL_W-1:0]`, then the page from `dq_in[PAGE_AW-1:0]`. Further address cycles are ignored.
- R3: After program setup, each data cycle (both latch inputs low, rising `wr_stb_n`) writes `dq_in` into the page buffer at the column and increments the column. Program go copies the whole buffer into the addressed page.
- R4: Read go copies the addressed page into the buffer. After that, each falling `rd_stb_n` with chip enable low puts the buffer word at the column on `dq_out` and increments the column modulo `2**COL_W`.
- R5: `ready` is low for exactly `T_RD`, `T_PG` or `T_ER` clock cycles after a read, program or erase starts, and is high otherwise.
- R6: Erase sets every word of the `2**BLK_AW` aligned pages that contain the addressed page to all ones, and leaves every other page unchanged.
- R7: While `wr_prot_n` is low, program go and erase go are refused: `ready` stays high and the array is unchanged. Reads are unaffected.
- R8: When `lock_strap` is high and `wr_prot_n` is low, `all_locked` sets and stays set after `wr_prot_n` returns high. While it is set, program and erase are refused as in R7. `lock_strap` low clears it and keeps it clear.
- R9: Chip enable going high during busy neither stops nor shortens the operation. Chip enable high while idle cancels a partly entered command sequence.
- R10: A write cycle with both latch inputs high changes neither the command sequence nor the address registers.
- R11: `dq_oe` is high only when chip enable, `rd_stb_n`, `cmd_latch` and `addr_latch` are all low, as sampled three cycles earlier.
- R12: After reset, `ready` is 1 and `dq_oe`, `all_locked` and `dq_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en_n | input | 1 | Chip enable, active low |
| cmd_latch | input | 1 | Marks a write cycle as a command |
| addr_latch | input | 1 | Marks a write cycle as an address |
| wr_stb_n | input | 1 | Write strobe; its rising edge latches |
| rd_stb_n | input | 1 | Read strobe; its falling edge outputs a word |
| wr_prot_n | input | 1 | Write protect, active low |
| lock_strap | input | 1 | Enables the global lock |
| dq_in | input | IO_W | Bus data in |
| dq_out | output | IO_W | Bus data out |
| dq_oe | output | 1 | Bus output enable |
| ready | output | 1 | High when no operation is busy |
| all_locked | output | 1 | Global lock state |

## Verification
The bench programs every page with its own pattern, then reads each page back from a different start column. This catches a column counter that fails to wrap, or a read that starts from column 0 instead of the loaded column. The command words carry junk in the upper byte, so a decoder that looks at all 16 bits would ignore every command. The bench erases through the upper page of a block, so an erase that forgets to align to the block would wipe the wrong pages. It then reads the neighbouring pages, so an erase that overruns would be seen. Further cases cover protect and lock refusals, lock persistence, chip enable high during busy and while idle, both-latch cycles, and output-enable gating. A design that got any of these wrong would show a nonzero busy length, stale or overwritten page data, or a wrong `dq_oe`.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam logic [7:0] OPC_READ_SET  = 8'h00;
  localparam logic [7:0] OPC_READ_GO   = 8'h30;
  localparam logic [7:0] OPC_PROG_SET  = 8'h80;
  localparam logic [7:0] OPC_PROG_GO   = 8'h10;
  localparam logic [7:0] OPC_ERASE_SET = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO  = 8'hD0;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_READ, SEQ_PROG, SEQ_ERASE} seq_e;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG, OP_ERASE} op_e;
endpackage

// File: rtl/flash_fe_sync.sv
module flash_fe_sync #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/flash_fe_timer.sv
module flash_fe_timer #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          busy,
  output logic [TW-1:0] step
);
  logic [TW-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      step  <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      step  <= '0;
      len_q <= len;
    end else if (busy) begin
      step <= step + 1'b1;
      if (step == len_q - 1'b1) busy <= 1'b0;
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && step != len_q - 1'b1) |=> busy);

  // R5
  step_bound_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (step < len_q));

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/flash_fe_array.sv
module flash_fe_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/flash_bus_fe.sv
module flash_bus_fe
  import flash_fe_pkg::*;
#(
  parameter int IO_W    = 16,
  parameter int COL_W   = 3,
  parameter int PAGE_AW = 3,
  parameter int BLK_AW  = 1,
  parameter int T_RD    = 12,
  parameter int T_PG    = 20,
  parameter int T_ER    = 30
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            chip_en_n,
  input  logic            cmd_latch,
  input  logic            addr_latch,
  input  logic            wr_stb_n,
  input  logic            rd_stb_n,
  input  logic            wr_prot_n,
  input  logic            lock_strap,
  input  logic [IO_W-1:0] dq_in,
  output logic [IO_W-1:0] dq_out,
  output logic            dq_oe,
  output logic            ready,
  output logic            all_locked
);
  localparam int PAGE_WORDS = 1 << COL_W;
  localparam int BLK_WORDS  = 1 << (COL_W + BLK_AW);
  localparam int AW         = COL_W + PAGE_AW;
  localparam int TMAX_A     = (T_RD > T_PG) ? T_RD : T_PG;
  localparam int TMAX       = (TMAX_A > T_ER) ? TMAX_A : T_ER;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int SW         = IO_W + 7;
  localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, {IO_W{1'b0}}};
  localparam logic [TW-1:0] PW_T = TW'(PAGE_WORDS);
  localparam logic [TW-1:0] BW_T = TW'(BLK_WORDS);

  // synchronised pins
  logic [SW-1:0]   s_now;
  logic            ce_s, cl_s, al_s, we_s, re_s, wp_s, st_s;
  logic [IO_W-1:0] dq_s;
  logic            we_d, re_d;

  flash_fe_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst(rst),
    .d({chip_en_n, cmd_latch, addr_latch, wr_stb_n, rd_stb_n, wr_prot_n, lock_strap, dq_in}),
    .q(s_now)
  );
  assign {ce_s, cl_s, al_s, we_s, re_s, wp_s, st_s, dq_s} = s_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_d <= 1'b1;
      re_d <= 1'b1;
    end else begin
      we_d <= we_s;
      re_d <= re_s;
    end
  end

  // decoded events
  logic       busy;
  logic [TW-1:0] step;
  logic       we_rise, re_fall, cmd_ev, adr_ev, dat_ev, rd_ev, prot;
  logic [7:0] opc;
  seq_e       seq_q;
  op_e        op_q;
  logic [1:0] acnt_q;
  logic [COL_W-1:0]   col_q;
  logic [PAGE_AW-1:0] page_q;
  logic       lock_q;
  logic       go_rd, go_pg, go_er, start;
  logic [TW-1:0] len;

  assign opc     = dq_s[7:0];
  assign we_rise = we_s & ~we_d & ~ce_s;
  assign re_fall = ~re_s & re_d & ~ce_s;
  assign cmd_ev  = ~busy & we_rise & cl_s & ~al_s;
  assign adr_ev  = ~busy & we_rise & al_s & ~cl_s;
  assign dat_ev  = ~busy & we_rise & ~al_s & ~cl_s & (seq_q == SEQ_PROG);
  assign rd_ev   = ~busy & re_fall;
  assign prot    = ~wp_s | lock_q;

  assign go_rd = cmd_ev & (opc == OPC_READ_GO)  & (seq_q == SEQ_READ);
  assign go_pg = cmd_ev & (opc == OPC_PROG_GO)  & (seq_q == SEQ_PROG)  & ~prot;
  assign go_er = cmd_ev & (opc == OPC_ERASE_GO) & (seq_q == SEQ_ERASE) & ~prot;
  assign start = go_rd | go_pg | go_er;
  assign len   = go_rd ? TW'(T_RD) : (go_pg ? TW'(T_PG) : TW'(T_ER));

  flash_fe_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .start(start), .len(len), .busy(busy), .step(step)
  );

  // command sequence, address, column, outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q  <= SEQ_IDLE;
      op_q   <= OP_NONE;
      acnt_q <= '0;
      col_q  <= '0;
      page_q <= '0;
      dq_out <= '0;
      dq_oe  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      dq_oe  <= ~ce_s & ~re_s & ~cl_s & ~al_s;
      lock_q <= st_s & (lock_q | ~wp_s);
      if (start) begin
        op_q <= go_rd ? OP_READ : (go_pg ? OP_PROG : OP_ERASE);
      end
      if (!busy) begin
        if (ce_s) begin
          seq_q <= SEQ_IDLE;
        end else if (cmd_ev) begin
          acnt_q <= '0;
          case (opc)
            OPC_READ_SET:  seq_q <= SEQ_READ;
            OPC_PROG_SET:  seq_q <= SEQ_PROG;
            OPC_ERASE_SET: seq_q <= SEQ_ERASE;
            default:       seq_q <= SEQ_IDLE;
          endcase
        end else if (adr_ev && seq_q != SEQ_IDLE && acnt_q != 2'd2) begin
          if (acnt_q == 2'd0) col_q <= opc[COL_W-1:0];
          else                page_q <= opc[PAGE_AW-1:0];
          acnt_q <= acnt_q + 1'b1;
        end else if (dat_ev) begin
          col_q <= col_q + 1'b1;
        end else if (rd_ev) begin
          dq_out <= pbuf[col_q];
          col_q  <= col_q + 1'b1;
        end
      end
    end
  end

  // page buffer and cell array transfers
  logic [IO_W-1:0] pbuf [PAGE_WORDS];
  logic            fill_en;
  logic [COL_W-1:0] fill_idx;
  logic            arr_we;
  logic [AW-1:0]   arr_wa, arr_ra;
  logic [IO_W-1:0] arr_wd, arr_rd;

  assign fill_en  = busy & (op_q == OP_READ) & (step != '0) & (step <= PW_T);
  assign fill_idx = COL_W'(step - 1'b1);
  assign arr_ra   = {page_q, step[COL_W-1:0]};

  always_ff @(posedge clk) begin
    if (fill_en)     pbuf[fill_idx] <= arr_rd;
    else if (dat_ev) pbuf[col_q]    <= dq_s;
  end

  always_comb begin
    arr_we = 1'b0;
    arr_wa = {page_q, step[COL_W-1:0]};
    arr_wd = pbuf[step[COL_W-1:0]];
    if (busy && op_q == OP_PROG && step < PW_T) begin
      arr_we = 1'b1;
    end else if (busy && op_q == OP_ERASE && step < BW_T) begin
      arr_we = 1'b1;
      arr_wa = {page_q[PAGE_AW-1:BLK_AW], step[BLK_AW+COL_W-1:0]};
      arr_wd = '1;
    end
  end

  flash_fe_array #(.AW(AW), .DW(IO_W)) u_cells (
    .clk(clk), .we(arr_we), .waddr(arr_wa), .wdata(arr_wd),
    .raddr(arr_ra), .rdata(arr_rd)
  );

  assign ready      = ~busy;
  assign all_locked = lock_q;

  // R10
  both_latch_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && we_rise && cl_s && al_s) |=> ($stable(seq_q) && $stable(acnt_q) && $stable(page_q) && $stable(col_q)));

  // R7
  prot_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && (opc == OPC_PROG_GO || opc == OPC_ERASE_GO) && prot) |=> ready);

  // R11
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (!$past(ce_s) && !$past(re_s) && !$past(cl_s) && !$past(al_s)));

  // R4
  col_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && !ce_s) |=> (col_q == $past(col_q) + 1'b1));

  // R8
  lock_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !st_s |=> !all_locked);

  // R9
  busy_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(seq_q) && $stable(page_q)));
endmodule

// File: tb/tb_flash_bus_fe.sv
module tb_flash_bus_fe;
  localparam int IO_W = 16;
  localparam int COL_W = 3;
  localparam int PAGE_AW = 3;
  localparam int BLK_AW = 1;
  localparam int T_RD = 12;
  localparam int T_PG = 20;
  localparam int T_ER = 30;
  localparam int NW = 8;
  localparam int NP = 8;
  localparam int WIN = T_ER + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chip_en_n = 1'b1, cmd_latch = 1'b0, addr_latch = 1'b0;
  logic wr_stb_n = 1'b1, rd_stb_n = 1'b1, wr_prot_n = 1'b1, lock_strap = 1'b0;
  logic [IO_W-1:0] dq_in = '0;
  logic [IO_W-1:0] dq_out;
  logic dq_oe, ready, all_locked;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [15:0] exp_mem [NP*NW];

  always #2 clk = ~clk;

  flash_bus_fe #(.IO_W(IO_W), .COL_W(COL_W), .PAGE_AW(PAGE_AW), .BLK_AW(BLK_AW),
                 .T_RD(T_RD), .T_PG(T_PG), .T_ER(T_ER)) dut (
    .clk(clk), .rst(rst), .chip_en_n(chip_en_n), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_stb_n(wr_stb_n), .rd_stb_n(rd_stb_n),
    .wr_prot_n(wr_prot_n), .lock_strap(lock_strap), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .ready(ready), .all_locked(all_locked)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  function automatic logic [15:0] pat(int p, int c, logic [15:0] seed);
    return 16'(p * 16'h0731) ^ 16'(c * 16'h0113) ^ seed;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic c, logic a, logic [15:0] d);
    @(negedge clk);
    cmd_latch = c; addr_latch = a; dq_in = d; wr_stb_n = 1'b0;
    wait_n(3);
    wr_stb_n = 1'b1;
    wait_n(2);
    cmd_latch = 1'b0; addr_latch = 1'b0;
  endtask

  task automatic rd(output logic [15:0] d, output logic oe);
    @(negedge clk);
    rd_stb_n = 1'b0;
    wait_n(4);
    d = dq_out; oe = dq_oe;
    rd_stb_n = 1'b1;
    wait_n(3);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (!ready) n++;
    end
  endtask

  // command words carry junk in the upper byte (R1)
  task automatic prog(int p, logic [15:0] seed, bit ok, string req);
    int n;
    wr(1, 0, 16'hA580);
    wr(0, 1, 16'h5A00);
    wr(0, 1, 16'h7E00 | 16'(p));
    for (int c = 0; c < NW; c++) wr(0, 0, pat(p, c, seed));
    wr(1, 0, 16'h3C10);
    busy_len(n);
    chk(req, n, ok ? T_PG : 0);
    if (ok) for (int c = 0; c < NW; c++) exp_mem[p*NW+c] = pat(p, c, seed);
  endtask

  task automatic erase(int p, bit ok, string req);
    int n;
    int b;
    wr(1, 0, 16'hC360);
    wr(0, 1, 16'h0000);
    wr(0, 1, 16'(p));
    wr(1, 0, 16'h11D0);
    busy_len(n);
    chk(req, n, ok ? T_ER : 0);
    b = (p >> BLK_AW) << BLK_AW;
    if (ok) for (int i = 0; i < (NW << BLK_AW); i++) exp_mem[b*NW+i] = 16'hFFFF;
  endtask

  task automatic read_page(int p, int c, string req);
    int n;
    logic [15:0] d;
    logic oe;
    wr(1, 0, 16'h9900);
    wr(0, 1, 16'hF000 | 16'(c));
    wr(0, 1, 16'(p));
    wr(1, 0, 16'h8830);
    busy_len(n);
    chk("R5 read busy", n, T_RD);
    for (int i = 0; i <= NW; i++) begin
      rd(d, oe);
      chk(req, d, exp_mem[p*NW + ((c + i) % NW)]);
      if (i == 0) chk("R11 oe during read", oe, 1);
    end
  endtask

  initial begin
    int n;
    logic [15:0] d;
    logic oe;
    wait_n(4);
    rst = 1'b0;
    chip_en_n = 1'b0;
    wait_n(3);
    // R12 reset state
    chk("R12 ready", ready, 1);
    chk("R12 oe", dq_oe, 0);
    chk("R12 locked", all_locked, 0);
    chk("R12 dq_out", dq_out, 0);

    // R1 R3 R5: program every page
    for (int p = 0; p < NP; p++) prog(p, 16'h1000, 1, "R3 program busy");
    // R2 R4: read back each page from its own start column, with wrap
    for (int p = 0; p < NP; p++) read_page(p, p, "R4 read data");

    // R6: erase through the upper page of block 1
    erase(3, 1, "R6 erase busy");
    for (int p = 1; p <= 4; p++) read_page(p, 0, "R6 erase data");

    // R7: protect refuses program and erase
    wr_prot_n = 1'b0;
    wait_n(4);
    chk("R8 no lock with strap low", all_locked, 0);
    prog(0, 16'h2222, 0, "R7 program refused");
    erase(0, 0, "R7 erase refused");
    wr_prot_n = 1'b1;
    wait_n(4);
    read_page(0, 2, "R7 array unchanged");

    // R8: lock arming, persistence, refusal, clearing
    lock_strap = 1'b1;
    wait_n(4);
    wr_prot_n = 1'b0;
    wait_n(4);
    wr_prot_n = 1'b1;
    wait_n(4);
    chk("R8 lock set", all_locked, 1);
    prog(1, 16'h3333, 0, "R8 program refused");
    erase(1, 0, "R8 erase refused");
    read_page(1, 0, "R8 array unchanged");
    lock_strap = 1'b0;
    wait_n(4);
    chk("R8 lock cleared", all_locked, 0);
    prog(1, 16'h4444, 1, "R8 program after clear");
    read_page(1, 5, "R8 data after clear");

    // R9: chip enable high during busy is ignored
    wr(1, 0, 16'h0080);
    wr(0, 1, 16'h0000);
    wr(0, 1, 16'h0006);
    for (int c = 0; c < NW; c++) wr(0, 0, pat(6, c, 16'h5555));
    wr(1, 0, 16'h0010);
    chip_en_n = 1'b1;
    busy_len(n);
    chip_en_n = 1'b0;
    chk("R9 busy with ce high", n, T_PG);
    for (int c = 0; c < NW; c++) exp_mem[6*NW+c] = pat(6, c, 16'h5555);
    read_page(6, 3, "R9 program completed");

    // R9: chip enable high while idle cancels the sequence
    wr(1, 0, 16'h0080);
    wr(0, 1, 16'h0000);
    wr(0, 1, 16'h0007);
    for (int c = 0; c < NW; c++) wr(0, 0, 16'hBEEF);
    chip_en_n = 1'b1;
    wait_n(5);
    chip_en_n = 1'b0;
    wait_n(3);
    wr(1, 0, 16'h0010);
    busy_len(n);
    chk("R9 cancelled sequence", n, 0);
    read_page(7, 0, "R9 page untouched");

    // R10: both latch inputs high are ignored
    wr(1, 0, 16'h0000);
    wr(0, 1, 16'h0000);
    wr(0, 1, 16'h0005);
    wr(1, 1, 16'h0030);
    busy_len(n);
    chk("R10 both-high not a command", n, 0);
    wr(1, 1, 16'h0002);
    wr(1, 0, 16'h0030);
    busy_len(n);
    chk("R10 read still starts", n, T_RD);
    for (int i = 0; i < 3; i++) begin
      rd(d, oe);
      chk("R10 address unchanged", d, exp_mem[5*NW+i]);
    end

    // R11: output enable gating
    cmd_latch = 1'b1;
    rd_stb_n = 1'b0;
    wait_n(4);
    chk("R11 oe off with cmd_latch", dq_oe, 0);
    cmd_latch = 1'b0;
    wait_n(4);
    chk("R11 oe on", dq_oe, 1);
    chip_en_n = 1'b1;
    wait_n(4);
    chk("R11 oe off with ce high", dq_oe, 0);
    rd_stb_n = 1'b1;
    chip_en_n = 1'b0;
    wait_n(4);
    chk("R11 oe off with rd high", dq_oe, 0);

    summary();
    $finish;
  end
endmodule